// File: doc/BRIEF.md
# Transceiver Power Mode Controller

This block chooses the operating mode of a CAN line-interface control core. It samples two active control pins (a standby request pin that is active low and an enable pin). It also samples comparator bits from the three supply monitors (core rail, I/O rail, battery) and a wake flag that a neighbouring block supplies. From these inputs it selects one of five modes: Normal, Listen-only, Standby, Go-to-Sleep and Sleep. Each mode sets the analog controls: transmitter enable, receiver bias level, the enable of the mid-supply common-mode output, and the enable of the regulator inhibit output.

The block holds the combined core/I/O undervoltage flag, together with its detection and recovery timers. While that flag is set, the block stays in Sleep whatever the pins say. A separate battery undervoltage indication only demotes an active request to Standby. Sleep can be reached from the pins only after a timed Go-to-Sleep hold. Once in Sleep, the enable pin has no effect.

Both control pins and all supply bits are asynchronous and pass through two-flop synchronisers. All times are counted in clock cycles.

Top module: `xcvr_pwr_mode_ctrl`

## Requirements
- R1: With no undervoltage flag set, the mode decodes from the synchronised pins as follows. Standby-pin high with enable high gives Normal. Standby-pin high with enable low gives Listen-only. Standby-pin low with enable high and the wake flag clear gives Go-to-Sleep. Standby-pin low with enable low, or with the wake flag set, gives Standby. The mode code on `mode_o` is Normal=0, Listen-only=1, Standby=2, Go-to-Sleep=3, Sleep=4. A pin change appears on `mode_o` three clock edges after it is applied.
- R2: Go-to-Sleep is held for exactly HOLD_CYC cycles and is then followed by Sleep.
- R3: A change of either pin, or a set wake flag, before the hold expires leaves Go-to-Sleep, and the hold count restarts from zero.
- R4: In Sleep, with the standby pin low and wake clear, the block stays in Sleep whatever the enable pin does. With the standby pin low and wake set, it moves to Standby. With the standby pin high, it moves to Normal or Listen-only according to the enable pin.
- R5: While the core/I/O undervoltage flag (`uv_flag_o`) is set, the next mode is Sleep from any mode.
- R6: With `uv_flag_o` clear and the battery undervoltage bit set, a high standby pin gives Standby instead of an active mode.
- R7: `uv_flag_o` sets after DET_CYC consecutive synchronised cycles in which the core rail or the I/O rail reports bad. A shorter dip has no effect.
- R8: `uv_flag_o` clears after REC_CYC consecutive cycles in which both rails are good. It also clears at once on a rising edge of the synchronised standby pin, a rising edge of the wake flag, or a rising edge of the power-on flag. Any clear restarts both timers.
- R9: `inh_en_o` is high in every mode except Sleep.
- R10: `split_en_o` and `bias_mid_o` are high only in Normal and Listen-only.
- R11: `tx_en_o` is high only in Normal.
- R12: During and after synchronous reset the block is in Standby with `inh_en_o` high and every other drive output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_n_i | input | 1 | Standby request pin, low requests a low-power mode (asynchronous) |
| en_i | input | 1 | Enable pin (asynchronous) |
| vcc_ok_i | input | 1 | Core rail above threshold (asynchronous) |
| vio_ok_i | input | 1 | I/O rail above threshold (asynchronous) |
| vbat_uv_i | input | 1 | Battery undervoltage indication (asynchronous) |
| wake_flag_i | input | 1 | Wake flag from the wake-detection block (synchronous) |
| pwon_flag_i | input | 1 | Power-on flag from the supply block (synchronous) |
| mode_o | output | 3 | Current mode code |
| tx_en_o | output | 1 | Transmitter enable |
| bias_mid_o | output | 1 | Receiver bias at mid-supply (low: ground) |
| split_en_o | output | 1 | Common-mode output driven to mid-supply |
| inh_en_o | output | 1 | Regulator inhibit output active |
| uv_flag_o | output | 1 | Core/I/O undervoltage flag |

## Verification
Two functions can resolve on the same edge. In the first, the Go-to-Sleep hold expires on the edge where the wake flag rises, and Standby must win over Sleep. The bench sweeps the wake pulse across every offset of the hold window and compares the mode on each cycle with its own model. In the second, the undervoltage detection window is still running when a standby-pin rising edge arrives. The clear must win and the detection count must restart, which the model judges by the cycle in which Sleep is finally forced.

// File: rtl/xpm_pkg.sv
package xpm_pkg;
  typedef enum logic [2:0] {
    XM_NORMAL  = 3'd0,
    XM_LISTEN  = 3'd1,
    XM_STANDBY = 3'd2,
    XM_GTS     = 3'd3,
    XM_SLEEP   = 3'd4
  } xm_mode_e;

  typedef struct packed {
    logic tx_en;
    logic bias_mid;
    logic split_en;
    logic inh_en;
  } xm_drive_t;

  // Analog control pattern for each mode
  function automatic xm_drive_t drive_of(xm_mode_e m);
    xm_drive_t d;
    d.tx_en    = (m == XM_NORMAL);
    d.bias_mid = (m == XM_NORMAL) || (m == XM_LISTEN);
    d.split_en = (m == XM_NORMAL) || (m == XM_LISTEN);
    d.inh_en   = (m != XM_SLEEP);
    return d;
  endfunction
endpackage

// File: rtl/xpm_sync.sv
module xpm_sync #(
  parameter int          WIDTH   = 5,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xpm_uv_monitor.sv
module xpm_uv_monitor #(
  parameter int DET_CYC = 64,
  parameter int REC_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_ok_s,
  input  logic vio_ok_s,
  input  logic stb_n_s,
  input  logic wake_flag,
  input  logic pwon_flag,
  output logic uv_flag
);
  localparam int DW = $clog2(DET_CYC + 1);
  localparam int RW = $clog2(REC_CYC + 1);
  localparam logic [DW-1:0] DET_LAST = DW'(DET_CYC - 1);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);

  logic [DW-1:0] det_cnt;
  logic [RW-1:0] rec_cnt;
  logic          stb_prev, wake_prev, pwon_prev;
  logic          clr_evt, rail_bad;

  assign rail_bad = !vcc_ok_s || !vio_ok_s;
  assign clr_evt  = (stb_n_s && !stb_prev) || (wake_flag && !wake_prev) ||
                    (pwon_flag && !pwon_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev  <= 1'b0;
      wake_prev <= 1'b0;
      pwon_prev <= 1'b0;
    end else begin
      stb_prev  <= stb_n_s;
      wake_prev <= wake_flag;
      pwon_prev <= pwon_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_flag <= 1'b0;
      det_cnt <= '0;
      rec_cnt <= '0;
    end else if (clr_evt) begin
      uv_flag <= 1'b0;
      det_cnt <= '0;
      rec_cnt <= '0;
    end else if (!uv_flag) begin
      rec_cnt <= '0;
      if (!rail_bad) begin
        det_cnt <= '0;
      end else if (det_cnt == DET_LAST) begin
        uv_flag <= 1'b1;
        det_cnt <= '0;
      end else begin
        det_cnt <= det_cnt + 1'b1;
      end
    end else begin
      det_cnt <= '0;
      if (rail_bad) begin
        rec_cnt <= '0;
      end else if (rec_cnt == REC_LAST) begin
        uv_flag <= 1'b0;
        rec_cnt <= '0;
      end else begin
        rec_cnt <= rec_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xpm_mode_fsm.sv
module xpm_mode_fsm
  import xpm_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     stb_n_s,
  input  logic     en_s,
  input  logic     vbat_uv_s,
  input  logic     uv_flag,
  input  logic     wake_flag,
  output xm_mode_e mode_q,
  output xm_mode_e mode_nxt
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] hold_cnt;
  logic          hold_done;

  assign hold_done = (mode_q == XM_GTS) && (hold_cnt == HOLD_LAST);

  always_comb begin
    if (uv_flag) begin
      mode_nxt = XM_SLEEP;
    end else if (stb_n_s) begin
      if (vbat_uv_s)   mode_nxt = XM_STANDBY;
      else if (en_s)   mode_nxt = XM_NORMAL;
      else             mode_nxt = XM_LISTEN;
    end else if (mode_q == XM_SLEEP) begin
      mode_nxt = wake_flag ? XM_STANDBY : XM_SLEEP;
    end else if (wake_flag || !en_s) begin
      mode_nxt = XM_STANDBY;
    end else begin
      mode_nxt = hold_done ? XM_SLEEP : XM_GTS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= XM_STANDBY;
      hold_cnt <= '0;
    end else begin
      mode_q <= mode_nxt;
      if (mode_q == XM_GTS && mode_nxt == XM_GTS) hold_cnt <= hold_cnt + 1'b1;
      else                                          hold_cnt <= '0;
    end
  end
endmodule

// File: rtl/xpm_drive_reg.sv
module xpm_drive_reg
  import xpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  xm_mode_e  mode_nxt,
  output xm_drive_t drive_q
);
  always_ff @(posedge clk) begin
    if (rst) drive_q <= drive_of(XM_STANDBY);
    else     drive_q <= drive_of(mode_nxt);
  end
endmodule

// File: rtl/xcvr_pwr_mode_ctrl.sv
module xcvr_pwr_mode_ctrl
  import xpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DET_CYC     = 64,
  parameter int REC_CYC     = 16,
  parameter int HOLD_CYC    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb_n_i,
  input  logic       en_i,
  input  logic       vcc_ok_i,
  input  logic       vio_ok_i,
  input  logic       vbat_uv_i,
  input  logic       wake_flag_i,
  input  logic       pwon_flag_i,
  output logic [2:0] mode_o,
  output logic       tx_en_o,
  output logic       bias_mid_o,
  output logic       split_en_o,
  output logic       inh_en_o,
  output logic       uv_flag_o
);
  localparam int NSYNC = 5;
  // bit order: {vbat_uv, vio_ok, vcc_ok, en, stb_n}; rails idle as good
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b01100;

  logic [NSYNC-1:0] raw_in, syn;
  xm_mode_e         mode_q, mode_nxt;
  xm_drive_t        drive_q;
  logic             uv_flag;

  assign raw_in = {vbat_uv_i, vio_ok_i, vcc_ok_i, en_i, stb_n_i};

  xpm_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(syn)
  );

  xpm_uv_monitor #(.DET_CYC(DET_CYC), .REC_CYC(REC_CYC)) u_uv (
    .clk(clk), .rst(rst), .vcc_ok_s(syn[2]), .vio_ok_s(syn[3]),
    .stb_n_s(syn[0]), .wake_flag(wake_flag_i), .pwon_flag(pwon_flag_i),
    .uv_flag(uv_flag)
  );

  xpm_mode_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk(clk), .rst(rst), .stb_n_s(syn[0]), .en_s(syn[1]),
    .vbat_uv_s(syn[4]), .uv_flag(uv_flag), .wake_flag(wake_flag_i),
    .mode_q(mode_q), .mode_nxt(mode_nxt)
  );

  xpm_drive_reg u_drv (
    .clk(clk), .rst(rst), .mode_nxt(mode_nxt), .drive_q(drive_q)
  );

  assign mode_o     = mode_q;
  assign tx_en_o    = drive_q.tx_en;
  assign bias_mid_o = drive_q.bias_mid;
  assign split_en_o = drive_q.split_en;
  assign inh_en_o   = drive_q.inh_en;
  assign uv_flag_o  = uv_flag;
endmodule

// File: rtl/xpm_chk.sv
module xpm_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_o,
  input logic       tx_en_o,
  input logic       split_en_o,
  input logic       inh_en_o,
  input logic       uv_flag_o
);
  localparam logic [2:0] M_NORMAL = 3'd0;
  localparam logic [2:0] M_LISTEN = 3'd1;
  localparam logic [2:0] M_GTS    = 3'd3;
  localparam logic [2:0] M_SLEEP  = 3'd4;

  a_r11_tx_only_normal: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> (mode_o == M_NORMAL));

  a_r9_inh_off_in_sleep: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_SLEEP) == !inh_en_o);

  a_r10_split_active_modes: assert property (@(posedge clk) disable iff (rst)
    split_en_o == ((mode_o == M_NORMAL) || (mode_o == M_LISTEN)));

  a_r5_uv_forces_sleep: assert property (@(posedge clk) disable iff (rst)
    uv_flag_o |=> (mode_o == M_SLEEP));

  a_r2_sleep_entry_path: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == M_SLEEP) && ($past(mode_o) != M_SLEEP)) |->
      (($past(mode_o) == M_GTS) || $past(uv_flag_o)));

  a_r1_mode_code_legal: assert property (@(posedge clk) disable iff (rst)
    mode_o <= M_SLEEP);
endmodule

bind xcvr_pwr_mode_ctrl xpm_chk u_chk (
  .clk(clk), .rst(rst), .mode_o(mode_o), .tx_en_o(tx_en_o),
  .split_en_o(split_en_o), .inh_en_o(inh_en_o), .uv_flag_o(uv_flag_o)
);

// File: tb/xcvr_pwr_mode_ctrl_bench.sv
module xcvr_pwr_mode_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int DET  = 64;
  localparam int REC  = 16;
  localparam int HOLD = 8;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb_n = 1'b0, en = 1'b0, vcc_ok = 1'b1, vio_ok = 1'b1, vbat_uv = 1'b0;
  logic wake = 1'b0, pwon = 1'b0;
  logic [2:0] mode;
  logic tx_en, bias_mid, split_en, inh_en, uv_flag;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  xcvr_pwr_mode_ctrl #(.SYNC_STAGES(2), .DET_CYC(DET), .REC_CYC(REC), .HOLD_CYC(HOLD))
  u_xcvr_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .stb_n_i(stb_n), .en_i(en), .vcc_ok_i(vcc_ok),
    .vio_ok_i(vio_ok), .vbat_uv_i(vbat_uv), .wake_flag_i(wake),
    .pwon_flag_i(pwon), .mode_o(mode), .tx_en_o(tx_en), .bias_mid_o(bias_mid),
    .split_en_o(split_en), .inh_en_o(inh_en), .uv_flag_o(uv_flag)
  );

  // ---------------- behavioural reference model ----------------
  logic [4:0] sq[$];   // synchroniser pipeline, oldest first
  int m_mode, m_uv, m_det, m_rec, m_hold;
  int p_stb, p_wake, p_pwon;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 2; m_uv = 0; m_det = 0; m_rec = 0; m_hold = 0;
      p_stb = 0; p_wake = 0; p_pwon = 0;
      sq = {5'b01100, 5'b01100};
    end else begin
      automatic logic [4:0] s = sq[0];
      automatic int s_stb = s[0], s_en = s[1], s_vcc = s[2], s_vio = s[3], s_vb = s[4];
      automatic int nm, nuv = m_uv, ndet = m_det, nrec = m_rec;
      automatic bit clr = (s_stb && !p_stb) || (wake && !p_wake) || (pwon && !p_pwon);
      automatic bit railbad = !s_vcc || !s_vio;
      // mode
      if (m_uv) nm = 4;
      else if (s_stb) nm = s_vb ? 2 : (s_en ? 0 : 1);
      else if (m_mode == 4) nm = wake ? 2 : 4;
      else if (wake || !s_en) nm = 2;
      else if (m_mode == 3 && m_hold + 1 >= HOLD) nm = 4;
      else nm = 3;
      m_hold = (m_mode == 3 && nm == 3) ? m_hold + 1 : 0;
      // undervoltage flag
      if (clr) begin nuv = 0; ndet = 0; nrec = 0; end
      else if (!m_uv) begin
        nrec = 0;
        ndet = railbad ? m_det + 1 : 0;
        if (ndet >= DET) begin nuv = 1; ndet = 0; end
      end else begin
        ndet = 0;
        nrec = railbad ? 0 : m_rec + 1;
        if (nrec >= REC) begin nuv = 0; nrec = 0; end
      end
      m_mode = nm; m_uv = nuv; m_det = ndet; m_rec = nrec;
      p_stb = s_stb; p_wake = wake; p_pwon = pwon;
      void'(sq.pop_front());
      sq.push_back({vbat_uv, vio_ok, vcc_ok, en, stb_n});
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(cur_req, "mode", mode, m_mode);
      chk("R9",  "inh_en", inh_en, m_mode != 4);
      chk("R10", "split_en", split_en, m_mode == 0 || m_mode == 1);
      chk("R10", "bias_mid", bias_mid, m_mode == 0 || m_mode == 1);
      chk("R11", "tx_en", tx_en, m_mode == 0);
      chk("R7", "uv_flag", uv_flag, m_uv);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    cyc(WATCHDOG_CYC);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    // R12: state during reset, then just after release
    chk("R12", "mode in reset", mode, 2);
    chk("R12", "inh in reset", inh_en, 1);
    rst = 1'b0;
    cyc(1);
    chk("R12", "mode after reset", mode, 2);
    chk("R12", "tx after reset", tx_en, 0);

    // R1: decode and three-edge latency
    cur_req = "R1";
    stb_n = 1; en = 1;
    cyc(2); chk("R1", "latency not yet", mode, 2);
    cyc(1); chk("R1", "normal", mode, 0);
    en = 0; cyc(5); chk("R1", "listen", mode, 1);
    stb_n = 0; cyc(5); chk("R1", "standby", mode, 2);

    // R2: timed hold then sleep
    cur_req = "R2";
    en = 1; cyc(3); chk("R2", "gts", mode, 3);
    cyc(HOLD - 1); chk("R2", "still gts", mode, 3);
    cyc(1); chk("R2", "sleep", mode, 4);

    // R4: sleep sticky against enable, wake leaves to standby
    cur_req = "R4";
    en = 0; cyc(6); chk("R4", "sleep en low", mode, 4);
    en = 1; cyc(6); chk("R4", "sleep en high", mode, 4);
    wake = 1; cyc(2); chk("R4", "wake to standby", mode, 2);
    wake = 0; cyc(HOLD + 4); chk("R4", "back to sleep", mode, 4);
    stb_n = 1; en = 0; cyc(4); chk("R4", "sleep to listen", mode, 1);

    // R3: abort by pin glitch, and wake swept over the hold window
    cur_req = "R3";
    stb_n = 0; en = 1; cyc(3 + HOLD - 3);
    en = 0; cyc(1); en = 1; cyc(4); chk("R3", "aborted gts", mode, 3);
    cyc(HOLD + 2); chk("R3", "sleep after restart", mode, 4);
    for (int off = 0; off < HOLD + 2; off++) begin
      stb_n = 0; en = 0; wake = 1; cyc(6);
      wake = 0; cyc(2);
      en = 1; cyc(3 + off);
      wake = 1; cyc(2); wake = 0;
      cyc(HOLD + 6);
      chk("R3", "sweep ends in sleep", mode, 4);
    end

    // R6: battery undervoltage demotes active request
    cur_req = "R6";
    stb_n = 1; en = 1; vbat_uv = 1; cyc(5); chk("R6", "vbat standby", mode, 2);
    vbat_uv = 0; cyc(5); chk("R6", "vbat recovered", mode, 0);

    // R7: short dip ignored, long dip sets flag and forces sleep (R5)
    cur_req = "R7";
    vio_ok = 0; cyc(DET - 4); vio_ok = 1; cyc(6);
    chk("R7", "short dip no flag", uv_flag, 0);
    vcc_ok = 0; cyc(DET + 4); chk("R7", "flag set", uv_flag, 1);
    cur_req = "R5";
    cyc(2); chk("R5", "forced sleep", mode, 4);

    // R8: recovery timer, then event clears
    cur_req = "R8";
    vcc_ok = 1; cyc(REC + 4); chk("R8", "recovered", uv_flag, 0);
    cyc(3); chk("R8", "back to normal", mode, 0);
    vcc_ok = 0; cyc(DET + 6); chk("R8", "set again", uv_flag, 1);
    stb_n = 0; cyc(4); stb_n = 1; cyc(3); chk("R8", "stb rise clears", uv_flag, 0);
    cyc(DET); chk("R8", "re-detects", uv_flag, 1);
    wake = 1; cyc(2); chk("R8", "wake clears", uv_flag, 0);
    wake = 0; cyc(DET + 2); chk("R8", "re-detects again", uv_flag, 1);
    pwon = 1; cyc(2); chk("R8", "pwon clears", uv_flag, 0);
    pwon = 0;
    // clear inside a running detection window restarts the count
    cyc(DET / 2); stb_n = 0; cyc(4); stb_n = 1; cyc(DET - 8);
    chk("R8", "restart holds flag low", uv_flag, 0);
    cyc(12); chk("R8", "flag after restart", uv_flag, 1);
    vcc_ok = 1; cyc(REC + 8);
    chk("R8", "final normal", mode, 0);

    finish_run();
  end
endmodule